// File: doc/BRIEF.md
# Serial Horner Polynomial Evaluator

This block computes the value of an unsigned polynomial f(x) = a0 + a1·x + … + aK·x^K. It uses Horner's rule and performs one multiply-accumulate step per clock. The coefficients arrive on a serial input, one per clock. The highest-order coefficient comes first and a0 comes last. The argument x stays unchanged while a sequence is being fed in.

A free-running slot counter, cleared by reset, tracks the position within each sequence of TERMS coefficients. During the a0 slot, the sum of the accumulator and the incoming coefficient is the finished value. On that slot's clock edge the value is captured into an output register, a valid strobe is raised for one clock, and the accumulator restarts from zero. A new sequence can therefore follow at once, with no further reset. Between strobes the output keeps the last finished value.

Elaboration parameters set the number of terms (3, 4 or 5) and the coefficient and x widths (2 to 4 bits each). The result port is 20 bits wide in every configuration. That width holds the largest value any permitted setting can produce.

Top module: `horner_eval`

## Requirements
- R1: While reset is asserted and afterwards, until the first full sequence of TERMS coefficients has been clocked in, `result` reads 0 and `result_vld` stays low.
- R2: Coefficients are sampled one per rising edge with the highest order first. In the cycle after the edge that samples a0, `result` equals the sum of a_i·x^i, using the x held during the sequence.
- R3: `result_vld` is high for exactly one cycle per sequence, in the cycle after the a0 edge. Successive strobes are exactly TERMS cycles apart.
- R4: While `result_vld` is low, `result` keeps the value of the most recent strobe (0 before the first strobe).
- R5: Sequences may follow each other with no gap and no reset. Each strobed value depends only on its own coefficients and x.
- R6: TERMS may be 3, 4 or 5, and COEF_W and X_W may each be 2 to 4. With TERMS=5 and 4-bit fields, the block strobes every 5 cycles with the correct value.
- R7: `result` is 20 bits wide for all settings. The worst case of all coefficients 15 with x = 15 and TERMS = 5 yields 813615 without overflow.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted in step with clk |
| coef_in | input | COEF_W | Serial coefficient, one per clock, highest order first |
| x_in | input | X_W | Polynomial argument, held for a whole sequence |
| result | output | 20 | Last finished polynomial value |
| result_vld | output | 1 | One-cycle strobe marking a new value on `result` |

## Verification
The bench builds the default configuration, with four terms, 3-bit coefficients and a 2-bit x. It sweeps every coefficient quadruple against every x, back to back, which reaches every carry pattern, the zero and all-ones coefficient cases, and the hold behaviour between all 16384 strobes. A second instance is built with five terms and 4-bit fields. It makes the five-cycle strobe spacing and the 813615 worst-case value on the fixed 20-bit result reachable.

// File: rtl/horner_pkg.sv
package horner_pkg;

  localparam int RES_W = 20;

  function automatic longint unsigned peak_value(input int terms, input int cw, input int xw);
    longint unsigned amax;
    longint unsigned xmax;
    longint unsigned pw;
    longint unsigned acc;
    amax = (longint'(1) << cw) - 1;
    xmax = (longint'(1) << xw) - 1;
    pw   = 1;
    acc  = 0;
    for (int i = 0; i < terms; i++) begin
      acc = acc + amax * pw;
      pw  = pw * xmax;
    end
    return acc;
  endfunction

endpackage

// File: rtl/horner_slot_ctr.sv
module horner_slot_ctr #(
  parameter int TERMS = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic last_slot
);
  localparam int SLOT_W = $clog2(TERMS);
  localparam logic [SLOT_W-1:0] LAST = SLOT_W'(TERMS - 1);

  logic [SLOT_W-1:0] slot_q;
  logic [SLOT_W-1:0] slot_d;

  assign last_slot = (slot_q == LAST);

  always_comb begin
    if (last_slot) slot_d = '0;
    else           slot_d = slot_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) slot_q <= '0;
    else        slot_q <= slot_d;
  end
endmodule

// File: rtl/horner_mac.sv
module horner_mac
  import horner_pkg::*;
#(
  parameter int COEF_W = 3,
  parameter int X_W    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [COEF_W-1:0] coef,
  input  logic [X_W-1:0]    x,
  input  logic              restart,
  output logic [RES_W-1:0]  acc,
  output logic [RES_W-1:0]  sum
);
  logic [RES_W-1:0] acc_q;
  logic [RES_W-1:0] acc_d;
  logic [RES_W-1:0] x_ext;

  assign x_ext = RES_W'(x);
  assign sum   = acc_q + RES_W'(coef);
  assign acc   = acc_q;

  always_comb begin
    if (restart) acc_d = '0;
    else         acc_d = x_ext * sum;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_d;
  end
endmodule

// File: rtl/horner_out_reg.sv
module horner_out_reg
  import horner_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [RES_W-1:0] value,
  output logic [RES_W-1:0] result,
  output logic             strobe
);
  logic [RES_W-1:0] res_q;
  logic [RES_W-1:0] res_d;
  logic             stb_q;

  always_comb begin
    res_d = res_q;
    if (load) res_d = value;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q <= '0;
      stb_q <= 1'b0;
    end else begin
      res_q <= res_d;
      stb_q <= load;
    end
  end

  assign result = res_q;
  assign strobe = stb_q;
endmodule

// File: rtl/horner_eval.sv
module horner_eval
  import horner_pkg::*;
#(
  parameter int TERMS  = 4,
  parameter int COEF_W = 3,
  parameter int X_W    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [COEF_W-1:0] coef_in,
  input  logic [X_W-1:0]    x_in,
  output logic [RES_W-1:0]  result,
  output logic              result_vld
);
  generate
    if (TERMS < 3 || TERMS > 5) begin : g_bad_terms
      $error("horner_eval: TERMS must be 3, 4 or 5");
    end
    if (COEF_W < 2 || COEF_W > 4 || X_W < 2 || X_W > 4) begin : g_bad_width
      $error("horner_eval: field widths must be 2 to 4 bits");
    end
  endgenerate

  logic             last_slot;
  logic [RES_W-1:0] acc_q;
  logic [RES_W-1:0] partial;

  horner_slot_ctr #(.TERMS(TERMS)) i_slot (
    .clk       (clk),
    .rst_n     (rst_n),
    .last_slot (last_slot)
  );

  horner_mac #(.COEF_W(COEF_W), .X_W(X_W)) i_mac (
    .clk     (clk),
    .rst_n   (rst_n),
    .coef    (coef_in),
    .x       (x_in),
    .restart (last_slot),
    .acc     (acc_q),
    .sum     (partial)
  );

  horner_out_reg i_out (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (last_slot),
    .value  (partial),
    .result (result),
    .strobe (result_vld)
  );
endmodule

// File: rtl/horner_eval_chk.sv
module horner_eval_chk
  import horner_pkg::*;
#(
  parameter int TERMS  = 4,
  parameter int COEF_W = 3,
  parameter int X_W    = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic [RES_W-1:0] result,
  input logic             result_vld,
  input logic [RES_W-1:0] acc
);
  localparam longint unsigned PEAK = peak_value(TERMS, COEF_W, X_W);
  localparam int CNT_W = $clog2(TERMS + 2);
  localparam logic [CNT_W-1:0] CAP = CNT_W'(TERMS);

  logic [CNT_W-1:0] since_rst;
  logic [CNT_W-1:0] gap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_rst <= '0;
      gap       <= '0;
    end else begin
      if (since_rst != CAP) since_rst <= since_rst + 1'b1;
      if (result_vld)       gap <= '0;
      else if (gap != CAP)  gap <= gap + 1'b1;
    end
  end

  // R1
  no_early_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst < CAP) |-> !result_vld);

  // R3
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    result_vld |=> !result_vld);

  // R3
  strobe_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
    result_vld |-> ((gap == CNT_W'(TERMS - 1)) || (since_rst == CAP && gap == CAP)));

  // R4
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !result_vld |-> $stable(result));

  // R5
  acc_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    result_vld |-> (acc == '0));

  // R7
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    64'(result) <= 64'(PEAK));
endmodule

bind horner_eval horner_eval_chk #(.TERMS(TERMS), .COEF_W(COEF_W), .X_W(X_W)) i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .result     (result),
  .result_vld (result_vld),
  .acc        (acc_q)
);

// File: tb/test_horner_eval.sv
module test_horner_eval;
  localparam int RW = 20;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [2:0]    coef_s = '0;
  logic [1:0]    x_s = '0;
  logic [RW-1:0] res_s;
  logic          vld_s;
  logic [3:0]    coef_b = '0;
  logic [3:0]    x_b = '0;
  logic [RW-1:0] res_b;
  logic          vld_b;

  int n_checks = 0;
  int n_fail   = 0;

  always #2ns clk = ~clk;

  horner_eval i_horner_eval (
    .clk(clk), .rst_n(rst_n), .coef_in(coef_s), .x_in(x_s),
    .result(res_s), .result_vld(vld_s)
  );

  horner_eval #(.TERMS(5), .COEF_W(4), .X_W(4)) i_horner_eval_max (
    .clk(clk), .rst_n(rst_n), .coef_in(coef_b), .x_in(x_b),
    .result(res_b), .result_vld(vld_b)
  );

  task automatic check(input string req, input string what, input longint got, input longint exp);
    n_checks++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, got, exp);
    end
  endtask

  function automatic longint poly(input int c[5], input int n, input int xv);
    longint s = 0;
    longint p = 1;
    for (int i = 0; i < n; i++) begin
      s = s + longint'(c[i]) * p;
      p = p * xv;
    end
    return s;
  endfunction

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  task automatic run_big(input int c[5], input int xv, inout longint held, input string req);
    for (int s = 0; s < 5; s++) begin
      x_b    = 4'(xv);
      coef_b = 4'(c[4 - s]);
      @(negedge clk);
      if (s == 4) begin
        held = poly(c, 5, xv);
        check(req, "strobe", vld_b, 1);
        check(req, "value", res_b, held);
      end else begin
        check("R6", "no strobe mid-sequence", vld_b, 0);
        check("R4", "held value", res_b, held);
      end
    end
  endtask

  initial begin
    #(200000 * 4ns);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    longint held;
    longint held_b;
    int c[5];

    repeat (3) @(negedge clk);
    // R1: outputs during reset
    check("R1", "result in reset", res_s, 0);
    check("R1", "valid in reset", vld_s, 0);
    rst_n = 1'b1;
    check("R1", "result after release", res_s, 0);
    check("R1", "valid after release", vld_s, 0);

    held = 0;
    for (int xv = 0; xv < 4; xv++) begin
      for (int v = 0; v < 4096; v++) begin
        for (int i = 0; i < 4; i++) c[i] = (v >> (3 * i)) & 7;
        c[4] = 0;
        for (int s = 0; s < 4; s++) begin
          x_s    = 2'(xv);
          coef_s = 3'(c[3 - s]);
          @(negedge clk);
          if (s == 3) begin
            held = poly(c, 4, xv);
            check("R3", "strobe on a0 slot", vld_s, 1);
            check((xv == 0 && v == 0) ? "R2" : "R5", "strobed value", res_s, held);
          end else begin
            check((xv == 0 && v == 0) ? "R1" : "R3", "valid low mid-sequence", vld_s, 0);
            check((xv == 0 && v == 0) ? "R1" : "R4", "held value", res_s, held);
          end
        end
      end
    end
    // R2: a specific ordering case, a3=1 others 0 with x=3 gives 27
    c = '{0, 0, 0, 1, 0};
    for (int s = 0; s < 4; s++) begin
      x_s = 2'd3; coef_s = 3'(c[3 - s]);
      @(negedge clk);
    end
    check("R2", "highest order first", res_s, 27);

    // second configuration: 5 terms, 4-bit fields
    rst_n = 1'b0;
    coef_b = '0; x_b = '0;
    @(negedge clk);
    check("R1", "max config result in reset", res_b, 0);
    check("R1", "max config valid in reset", vld_b, 0);
    rst_n = 1'b1;
    held_b = 0;
    c = '{15, 15, 15, 15, 15};
    run_big(c, 15, held_b, "R7");
    check("R7", "worst-case value", res_b, 813615);
    for (int xv = 0; xv < 16; xv++) begin
      for (int i = 0; i < 5; i++) c[i] = (xv * 7 + i * 5 + 3) % 16;
      run_big(c, xv, held_b, "R6");
    end
    c = '{0, 0, 0, 0, 0};
    run_big(c, 15, held_b, "R5");
    finish_run();
  end
endmodule